// File: doc/BRIEF.md
# Gated 22 kHz Tone Controller

This block produces the square-wave signalling tone for one output channel of a satellite receiver power stage and decides when that tone is present. A system-clock divider, set by the parameter `HALF_CYC` (system clocks per tone half-period), sets the tone frequency. With a 50 MHz clock, `HALF_CYC = 1136` gives close to 22 kHz at a 50 % duty cycle. Every start and stop delay is counted in whole half-periods of that same divider.

Two sources can request the tone. The first is an envelope input, `gate_in`, that carries modulated command data from a host controller. When the gate goes high the tone starts half a tone cycle later. When the gate goes low the tone keeps running for one more full cycle and then stops. The second source is a continuous-tone control. When it is set, the tone runs all the time and the gate input is ignored. Nothing is produced unless the tone function is armed, either by a register bit or by a dedicated pin, and the channel is out of standby.

The gate input is asynchronous and passes through a synchroniser. The register-style controls are taken as already synchronous to `clk`. The tone output sits low whenever no tone is being produced.

Top module: `tone_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first clock edges after it is released, `tone_out` and `tone_active` are both 0.
- R2: Tone enabled, continuous mode off, `gate_in` rising: `tone_out` stays 0 until the (`HALF_CYC`+2)-th rising edge after the first edge that samples `gate_in` high. On that edge `tone_out` becomes 1 and `tone_active` becomes 1 (two synchroniser edges, one arming edge, then `HALF_CYC` edges of delay).
- R3: While the tone runs, `tone_out` toggles every `HALF_CYC` clock edges, so the first high phase and every later phase last exactly `HALF_CYC` clocks (50 % duty).
- R4: The controller may see the synchronised gate low while the tone runs in gated mode. After that, `tone_out` keeps toggling through one further half-period boundary. At the second boundary it is forced to 0 and `tone_active` drops on the same edge.
- R5: If the synchronised gate goes high again before that second boundary, the stop is cancelled. The tone keeps toggling on its existing half-period grid with no shortened or extra phase.
- R6: If the synchronised gate falls before the half-cycle start delay has elapsed, no tone is produced. `tone_out` and `tone_active` stay 0.
- R7: When `cont_mode` is 1 and the tone is enabled, `tone_out` becomes 1 on the first rising edge at which both hold. It then toggles every `HALF_CYC` edges whatever `gate_in` does.
- R8: The tone is enabled when `tone_en_reg` or `tone_en_pin` is 1 (and `chan_en` is 1). If both are 0, `tone_active` and `tone_out` are 0 after the next rising edge, whatever `gate_in` and `cont_mode` do.
- R9: When `chan_en` is 0 (standby), `tone_out` and `tone_active` are 0 after the next rising edge, even if an enable and `cont_mode` are set.
- R10: `tone_out` is 0 in every cycle in which `tone_active` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_in | input | 1 | Asynchronous tone envelope; high requests the tone |
| tone_en_reg | input | 1 | Tone function enable from a control register |
| tone_en_pin | input | 1 | Tone function enable from a dedicated pin |
| cont_mode | input | 1 | 1 = tone runs continuously and the gate is ignored |
| chan_en | input | 1 | Channel enable; 0 = standby |
| tone_out | output | 1 | Tone square wave; low when idle |
| tone_active | output | 1 | 1 while a tone is being produced, including the stop tail |

## Verification
The bench builds the block with `HALF_CYC = 4` and the default two-stage synchroniser. A complete gated burst, including its start delay and its one-cycle tail, then fits in a few tens of clocks. Every half-period boundary falls on a clock edge the bench can name. This short grid makes the narrow windows easy to hit: a gate pulse that ends inside the start delay, and a gate that comes back inside the stop tail. It also lets the bench cover both enable sources, standby and continuous mode in one short run.

// File: rtl/tone_pkg.sv
// Shared definitions for the gated tone controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package tone_pkg;

    // Controller states: idle, waiting the half-cycle start delay,
    // tone running, tone running out its one-cycle stop tail.
    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_ARM   = 2'd1,
        TS_RUN   = 2'd2,
        TS_DRAIN = 2'd3
    } tone_state_e;

endpackage

// File: rtl/tone_gate_sync.sv
// Brings the asynchronous envelope input into the clk domain.
// Assumes: STAGES >= 1; the output lags the input by STAGES edges.
module tone_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;

            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= async_in;
            end

            assign sync_out = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;

            // Shift the input through a chain of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end

            assign sync_out = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tone_half_divider.sv
// Divides clk down to one tick per tone half-period.
// Assumes: HALF_CYC >= 2. 'restart' reloads the count so that the
// first tick comes HALF_CYC edges later. With 'run' low the count holds.
module tone_half_divider #(
    parameter int HALF_CYC = 1136
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam int            CW     = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    // A tick is the last clock of a half-period while running.
    assign tick = run && !restart && (cnt_q == '0);

    // Count down and reload at the end of each half-period or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (restart) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= RELOAD;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/tone_gate_fsm.sv
// Sequencer deciding when the tone runs and driving the waveform flop.
// Assumes: 'gate' is already synchronous; 'tick' comes from a divider
// whose restart and run inputs are driven by this module.
module tone_gate_fsm
    import tone_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cont,
    input  logic gate,
    input  logic tick,
    output logic div_restart,
    output logic div_run,
    output logic tone,
    output logic active
);

    tone_state_e state_q, state_d;
    logic        tone_q, tone_d;
    logic        tail_q, tail_d;   // one boundary of the stop tail already passed

    // Next-state and waveform decisions.
    always_comb begin
        state_d     = state_q;
        tone_d      = tone_q;
        tail_d      = tail_q;
        div_restart = 1'b0;
        if (!enable) begin
            state_d = TS_IDLE;
            tone_d  = 1'b0;
            tail_d  = 1'b0;
        end else begin
            unique case (state_q)
                TS_IDLE: begin
                    if (cont) begin
                        state_d     = TS_RUN;
                        tone_d      = 1'b1;
                        div_restart = 1'b1;
                    end else if (gate) begin
                        state_d     = TS_ARM;
                        div_restart = 1'b1;
                    end
                end
                TS_ARM: begin
                    if (cont) begin
                        state_d     = TS_RUN;
                        tone_d      = 1'b1;
                        div_restart = 1'b1;
                    end else if (!gate) begin
                        state_d = TS_IDLE;
                    end else if (tick) begin
                        state_d = TS_RUN;
                        tone_d  = 1'b1;
                    end
                end
                TS_RUN: begin
                    if (tick) tone_d = ~tone_q;
                    if (!gate && !cont) begin
                        state_d = TS_DRAIN;
                        tail_d  = 1'b0;
                    end
                end
                TS_DRAIN: begin
                    if (gate || cont) begin
                        state_d = TS_RUN;
                        if (tick) tone_d = ~tone_q;
                    end else if (tick) begin
                        if (tail_q) begin
                            state_d = TS_IDLE;
                            tone_d  = 1'b0;
                            tail_d  = 1'b0;
                        end else begin
                            tail_d = 1'b1;
                            tone_d = ~tone_q;
                        end
                    end
                end
                default: begin
                    state_d = TS_IDLE;
                    tone_d  = 1'b0;
                    tail_d  = 1'b0;
                end
            endcase
        end
    end

    // State, waveform and tail registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            tone_q  <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tone_q  <= tone_d;
            tail_q  <= tail_d;
        end
    end

    assign div_run = (state_q != TS_IDLE);
    assign tone    = tone_q;
    assign active  = (state_q == TS_RUN) || (state_q == TS_DRAIN);

endmodule

// File: rtl/tone_gate_ctrl.sv
// Top of the gated tone controller: enable qualification, envelope
// synchroniser, half-period divider and sequencer.
// Assumes: register-style controls are synchronous to clk; gate_in
// may be asynchronous. HALF_CYC >= 2, SYNC_STAGES >= 1.
module tone_gate_ctrl #(
    parameter int HALF_CYC    = 1136,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic tone_en_reg,
    input  logic tone_en_pin,
    input  logic cont_mode,
    input  logic chan_en,
    output logic tone_out,
    output logic tone_active
);

    logic gate_sync;
    logic tick;
    logic div_restart;
    logic div_run;
    logic tone_enable;

    // Tone function armed from either source, and only out of standby.
    assign tone_enable = (tone_en_reg || tone_en_pin) && chan_en;

    tone_gate_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gate_in),
        .sync_out (gate_sync)
    );

    tone_half_divider #(
        .HALF_CYC (HALF_CYC)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_restart),
        .run     (div_run),
        .tick    (tick)
    );

    tone_gate_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tone_enable),
        .cont        (cont_mode),
        .gate        (gate_sync),
        .tick        (tick),
        .div_restart (div_restart),
        .div_run     (div_run),
        .tone        (tone_out),
        .active      (tone_active)
    );

endmodule

// File: rtl/tone_gate_ctrl_chk.sv
// Property checker for tone_gate_ctrl, attached by bind below.
// Assumes: it observes top-level ports only.
module tone_gate_ctrl_chk #(
    parameter int HALF_CYC = 1136
) (
    input logic clk,
    input logic rst_n,
    input logic tone_en_reg,
    input logic tone_en_pin,
    input logic cont_mode,
    input logic chan_en,
    input logic tone_out,
    input logic tone_active
);

    localparam int            GW      = $clog2(HALF_CYC + 2) + 1;
    localparam logic [GW-1:0] GAP_MAX = {GW{1'b1}};

    logic          prev_tone_q;
    logic          prev_active_q;
    logic [GW-1:0] gap_q;
    logic          enabled;

    assign enabled = (tone_en_reg || tone_en_pin) && chan_en;

    // Track spacing between observed tone transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tone_q   <= 1'b0;
            prev_active_q <= 1'b0;
            gap_q         <= '0;
        end else begin
            prev_tone_q   <= tone_out;
            prev_active_q <= tone_active;
            if (tone_out != prev_tone_q) gap_q <= GW'(1);
            else if (gap_q != GAP_MAX)   gap_q <= gap_q + 1'b1;
        end
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_active |-> !tone_out);

    // R3
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tone_out != prev_tone_q) && tone_active && prev_active_q) |-> (gap_q == GW'(HALF_CYC)));

    // R7
    cont_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && cont_mode && !tone_active) |=> (tone_active && tone_out));

    // R8
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tone_en_reg || tone_en_pin) |=> !tone_active);

    // R9
    standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!tone_out && !tone_active));

endmodule

bind tone_gate_ctrl tone_gate_ctrl_chk #(
    .HALF_CYC (HALF_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tone_en_reg (tone_en_reg),
    .tone_en_pin (tone_en_pin),
    .cont_mode   (cont_mode),
    .chan_en     (chan_en),
    .tone_out    (tone_out),
    .tone_active (tone_active)
);

// File: tb/tone_gate_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected (cycle, tone, active)
// items, and a monitor compares them on falling edges.
module tone_gate_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int END_CYC    = 180;

    logic clk = 1'b0;
    logic rst_n;
    logic gate_in, tone_en_reg, tone_en_pin, cont_mode, chan_en;
    logic tone_out, tone_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_gate_ctrl #(
        .HALF_CYC    (HALF),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_in     (gate_in),
        .tone_en_reg (tone_en_reg),
        .tone_en_pin (tone_en_pin),
        .cont_mode   (cont_mode),
        .chan_en     (chan_en),
        .tone_out    (tone_out),
        .tone_active (tone_active)
    );

    typedef struct {
        int    at;
        logic  tone;
        logic  act;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc    = 0;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Count rising edges; item 'at' means "just after edge number at".
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop due items and compare them away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            n_run++;
            if (e.at != cyc) begin
                n_fail++;
                $display("FAIL %s: item for cycle %0d missed, now %0d", e.tag, e.at, cyc);
            end else if (tone_out !== e.tone || tone_active !== e.act) begin
                n_fail++;
                $display("FAIL %s at cycle %0d: tone_out=%b tone_active=%b, expected tone_out=%b tone_active=%b",
                         e.tag, cyc, tone_out, tone_active, e.tone, e.act);
            end
        end
    end

    task automatic expect_at(input int c, input logic t, input logic a, input string tag);
        sb.push_back('{at: c, tone: t, act: a, tag: tag});
    endtask

    task automatic go_to(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    // Driver: queue the expectations, then apply each scenario.
    initial begin
        rst_n = 1'b0; gate_in = 1'b0; tone_en_reg = 1'b0; tone_en_pin = 1'b0;
        cont_mode = 1'b0; chan_en = 1'b0;

        // R1 reset state
        expect_at(2, 1'b0, 1'b0, "R1");
        expect_at(4, 1'b0, 1'b0, "R1");
        go_to(3);
        rst_n = 1'b1;

        // Gated burst with register enable: R2 start, R3 period, R4 tail
        expect_at(16, 1'b0, 1'b0, "R2");
        expect_at(17, 1'b1, 1'b1, "R2");
        expect_at(20, 1'b1, 1'b1, "R3");
        expect_at(21, 1'b0, 1'b1, "R3");
        expect_at(25, 1'b1, 1'b1, "R3");
        expect_at(28, 1'b1, 1'b1, "R4");
        expect_at(29, 1'b0, 1'b0, "R4");
        expect_at(33, 1'b0, 1'b0, "R10");
        go_to(5);  chan_en = 1'b1; tone_en_reg = 1'b1;
        go_to(10); gate_in = 1'b1;
        go_to(19); gate_in = 1'b0;

        // Pin enable, retrigger inside the stop tail: R8, R5, then R4
        expect_at(46, 1'b0, 1'b0, "R2");
        expect_at(47, 1'b1, 1'b1, "R8");
        expect_at(55, 1'b1, 1'b1, "R5");
        expect_at(59, 1'b0, 1'b1, "R5");
        expect_at(63, 1'b1, 1'b1, "R5");
        expect_at(74, 1'b1, 1'b1, "R4");
        expect_at(75, 1'b0, 1'b0, "R4");
        go_to(38); tone_en_reg = 1'b0; tone_en_pin = 1'b1;
        go_to(40); gate_in = 1'b1;
        go_to(49); gate_in = 1'b0;
        go_to(51); gate_in = 1'b1;
        go_to(64); gate_in = 1'b0;

        // Gate pulse shorter than the start delay: R6
        expect_at(83, 1'b0, 1'b0, "R6");
        expect_at(87, 1'b0, 1'b0, "R6");
        expect_at(90, 1'b0, 1'b0, "R6");
        go_to(78); tone_en_pin = 1'b0; tone_en_reg = 1'b1;
        go_to(80); gate_in = 1'b1;
        go_to(81); gate_in = 1'b0;

        // Both enables low: gate ignored, R8
        expect_at(107, 1'b0, 1'b0, "R8");
        expect_at(111, 1'b0, 1'b0, "R8");
        expect_at(115, 1'b0, 1'b0, "R8");
        go_to(95);  tone_en_reg = 1'b0;
        go_to(100); gate_in = 1'b1;
        go_to(120); gate_in = 1'b0;

        // Continuous mode R7, gate ignored, standby R9, enable drop R8
        expect_at(131, 1'b1, 1'b1, "R7");
        expect_at(134, 1'b1, 1'b1, "R7");
        expect_at(135, 1'b0, 1'b1, "R3");
        expect_at(139, 1'b1, 1'b1, "R7");
        expect_at(143, 1'b0, 1'b1, "R7");
        expect_at(147, 1'b1, 1'b1, "R7");
        expect_at(150, 1'b0, 1'b0, "R9");
        expect_at(155, 1'b0, 1'b0, "R9");
        expect_at(161, 1'b1, 1'b1, "R7");
        expect_at(164, 1'b0, 1'b0, "R8");
        expect_at(170, 1'b0, 1'b0, "R10");
        go_to(130); tone_en_reg = 1'b1; cont_mode = 1'b1;
        go_to(136); gate_in = 1'b1;
        go_to(137); gate_in = 1'b0;
        go_to(149); chan_en = 1'b0;
        go_to(160); chan_en = 1'b1;
        go_to(163); tone_en_reg = 1'b0;
        go_to(165); cont_mode = 1'b0;

        go_to(END_CYC);
        @(negedge clk);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            n_fail++;
            $display("FAIL %s: item for cycle %0d never compared", e.tag, e.at);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: reached cycle %0d, expected finish by %0d", cyc, END_CYC + 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule